// File: doc/BRIEF.md
# Overwriting Receive Frame Ring Buffer

This block stores received network frames for a simple controller until a DMA engine drains them. Bytes arrive on a valid/ready stream that marks the first byte of a frame, its final byte, and, on that final byte, whether the frame was received with an error. Good frames go into a circular byte memory. Each frame sits behind a two-byte length header, and that header is written only when the frame completes. Until then the reader cannot see any part of the frame.

A second valid/ready stream hands the payload of the oldest stored frame to the DMA engine, one byte per transfer. The frame's space is freed after its last byte. If the reader falls behind, the writer does not stall and does not drop the new frame. It discards the oldest stored frames, one whole frame per cycle, until the incoming byte fits. If the discarded frame was partly read, the reader is told. Each committed frame raises a one-cycle interrupt pulse. Two status outputs give the number of stored frames and the length of the oldest one.

Back-pressure rules are as follows. On the input, a byte transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` drops only during cycles in which stored frames are being discarded. On the output, a byte transfers when `out_valid` and `out_ready` are both high. `out_data` and `out_last` hold while `out_ready` is low, unless an eviction intervenes.

Top module: `rx_frame_ring`

## Requirements
- R1: The store holds DEPTH bytes as a ring. The space in use is the sum, over stored frames, of payload length plus 2. It never exceeds DEPTH, and frames wrap past the top address.
- R2: A stored frame is a 2-byte length header (high byte first) followed by its payload. The read port delivers only the payload of the oldest frame, in arrival order, with `out_last` high on its final byte.
- R3: A byte with `in_sof` high starts a frame and throws away any unfinished frame. A byte with `in_eof` high ends it. Bytes received while no frame is open are accepted and ignored.
- R4: A frame of up to MAX_FRAME bytes is stored. A longer frame is never stored and raises no interrupt.
- R5: A frame whose final byte carries `in_err` high is discarded and raises no interrupt. Its space is reused by the next frame.
- R6: `rx_irq` is high for exactly one cycle: the cycle after the transfer of the final byte of each committed frame.
- R7: While a frame is still arriving, `stat_frames` and the read port do not change because of it.
- R8: When the next byte would not fit, `in_ready` goes low and one oldest whole frame is discarded per cycle until the byte fits.
- R9: If the discarded frame had at least one byte already read, `rd_lost` pulses in the next cycle. Reading then starts at the first payload byte of the new oldest frame.
- R10: `stat_frames` is the number of stored frames. `stat_head_len` is the payload length of the oldest frame, or 0 when the store is empty.
- R11: While `out_ready` is low and no eviction occurs, `out_valid` and `out_data` hold their values.
- R12: After reset the store is empty, `in_ready` is high, `out_valid`, `rx_irq` and `rd_lost` are low, and both status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Receive byte present |
| in_ready | output | 1 | Receive byte can be taken |
| in_data | input | 8 | Receive byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame error, meaningful with in_eof |
| out_valid | output | 1 | Payload byte of the oldest frame available |
| out_ready | input | 1 | DMA engine takes the byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Byte is the last of its frame |
| rx_irq | output | 1 | One-cycle pulse per committed frame |
| rd_lost | output | 1 | Pulse: the frame being read was discarded |
| stat_frames | output | CW | Number of stored frames |
| stat_head_len | output | 16 | Payload length of the oldest frame |

## Verification
`rx_irq` and `rd_lost` come from registers and are due in the cycle after the edge that caused them: the final-byte transfer for the interrupt, and the eviction edge for the lost pulse. The status outputs and `in_ready` change at that same edge. `out_data`, `out_last` and `out_valid` follow the stored state combinationally. The bench drives all inputs on falling edges and samples on the next falling edge. Every expected value is therefore read half a cycle after the edge that produced it. The bench keeps its own queue of frame lengths and seeds, and uses it to predict which frames eviction removes.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int unsigned HDR_BYTES = 2;

  // modular add for a ring of `depth` entries; off is always below depth
  function automatic int unsigned ring_add(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned depth);
    int unsigned s;
    s = base + off;
    return (s >= depth) ? s - depth : s;
  endfunction
endpackage

// File: rtl/rxr_store.sv
module rxr_store #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          we_d,
  input  logic [AW-1:0] wa_d,
  input  logic [7:0]    wd_d,
  input  logic          we_h,
  input  logic [AW-1:0] wa_h0,
  input  logic [AW-1:0] wa_h1,
  input  logic [7:0]    wd_h0,
  input  logic [7:0]    wd_h1,
  input  logic [AW-1:0] ra_x,
  output logic [7:0]    rd_x,
  input  logic [AW-1:0] ra_h0,
  input  logic [AW-1:0] ra_h1,
  output logic [7:0]    rd_h0,
  output logic [7:0]    rd_h1
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_d) mem[wa_d] <= wd_d;
    if (we_h) begin
      mem[wa_h0] <= wd_h0;
      mem[wa_h1] <= wd_h1;
    end
  end

  assign rd_x  = mem[ra_x];
  assign rd_h0 = mem[ra_h0];
  assign rd_h1 = mem[ra_h1];
endmodule

// File: rtl/rxr_assembler.sv
module rxr_assembler
  import rxr_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int MAX_FRAME = 1518,
  parameter int AW        = 11,
  parameter int CW        = 12,
  parameter int LW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_err,
  input  logic [CW-1:0] used,
  input  logic          frame_cnt_nz,
  output logic          evict_req,
  output logic          we_d,
  output logic [AW-1:0] wa_d,
  output logic [7:0]    wd_d,
  output logic          commit,
  output logic [AW-1:0] wa_h0,
  output logic [AW-1:0] wa_h1,
  output logic [15:0]   commit_len
);
  logic          active, drop;
  logic [AW-1:0] base;
  logic [LW-1:0] cnt;

  logic          start, takes_byte, over, want_write, short_room, fire;
  logic [LW-1:0] eff_cnt;

  always_comb begin
    start      = in_valid && in_sof;
    eff_cnt    = start ? '0 : cnt;
    takes_byte = in_valid && (start || (active && !drop));
    over       = takes_byte && (int'(eff_cnt) == MAX_FRAME);
    want_write = takes_byte && !over;
    short_room = want_write &&
                 (int'(used) + int'(HDR_BYTES) + 1 + int'(eff_cnt) > DEPTH);
    evict_req  = short_room && frame_cnt_nz;
    in_ready   = !short_room;
    fire       = in_valid && in_ready;
    we_d       = want_write && !short_room;
    wa_d       = AW'(ring_add(int'(base), int'(HDR_BYTES) + int'(eff_cnt), DEPTH));
    wd_d       = in_data;
    commit     = we_d && in_eof && !in_err;
    commit_len = 16'(int'(eff_cnt) + 1);
    wa_h0      = base;
    wa_h1      = AW'(ring_add(int'(base), 1, DEPTH));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      drop   <= 1'b0;
      base   <= '0;
      cnt    <= '0;
    end else if (fire && (start || active)) begin
      if (in_eof) begin
        active <= 1'b0;
        drop   <= 1'b0;
        cnt    <= '0;
        if (commit)
          base <= AW'(ring_add(int'(base), int'(commit_len) + int'(HDR_BYTES), DEPTH));
      end else begin
        active <= 1'b1;
        drop   <= (drop && !start) || over;
        if (we_d)       cnt <= LW'(int'(eff_cnt) + 1);
        else if (start) cnt <= '0;
      end
    end
  end

  // R8
  evict_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> frame_cnt_nz);

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= MAX_FRAME);
endmodule

// File: rtl/rxr_drain.sv
module rxr_drain
  import rxr_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int MAX_FRAME = 1518,
  parameter int AW        = 11,
  parameter int LW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_cnt_nz,
  input  logic          evict_req,
  input  logic [7:0]    rd_h0,
  input  logic [7:0]    rd_h1,
  input  logic [7:0]    rd_x,
  output logic [AW-1:0] ra_x,
  output logic [AW-1:0] ra_h0,
  output logic [AW-1:0] ra_h1,
  output logic [15:0]   head_len,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          pop,
  output logic          rd_lost
);
  logic [AW-1:0] head;
  logic [LW-1:0] idx;
  logic          xfer;

  always_comb begin
    head_len  = {rd_h0, rd_h1};
    ra_h0     = head;
    ra_h1     = AW'(ring_add(int'(head), 1, DEPTH));
    ra_x      = AW'(ring_add(int'(head), int'(HDR_BYTES) + int'(idx), DEPTH));
    out_valid = frame_cnt_nz && !evict_req;
    out_data  = rd_x;
    out_last  = (int'(idx) + 1 == int'(head_len));
    xfer      = out_valid && out_ready;
    pop       = evict_req || (xfer && out_last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      idx     <= '0;
      rd_lost <= 1'b0;
    end else begin
      rd_lost <= evict_req && (idx != '0);
      if (pop) begin
        head <= AW'(ring_add(int'(head), int'(head_len) + int'(HDR_BYTES), DEPTH));
        idx  <= '0;
      end else if (xfer) begin
        idx  <= LW'(int'(idx) + 1);
      end
    end
  end

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt_nz |-> (head_len != 16'd0 && int'(head_len) <= MAX_FRAME));

  // R9
  lost_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lost |-> idx == '0);
endmodule

// File: rtl/rx_frame_ring.sv
module rx_frame_ring
  import rxr_pkg::*;
#(
  parameter int DEPTH     = 2048,
  parameter int MAX_FRAME = 1518,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int LW = $clog2(MAX_FRAME + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          rx_irq,
  output logic          rd_lost,
  output logic [CW-1:0] stat_frames,
  output logic [15:0]   stat_head_len
);
  logic [CW-1:0] used, frame_cnt;
  logic          frame_cnt_nz, evict_req, we_d, commit, pop;
  logic [AW-1:0] wa_d, wa_h0, wa_h1, ra_x, ra_h0, ra_h1;
  logic [7:0]    wd_d, rd_x, rd_h0, rd_h1;
  logic [15:0]   commit_len, head_len;

  assign frame_cnt_nz = (frame_cnt != '0);

  rxr_assembler #(.DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME), .AW(AW), .CW(CW), .LW(LW)) u_asm (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sof, .in_eof, .in_err,
    .used, .frame_cnt_nz, .evict_req, .we_d, .wa_d, .wd_d,
    .commit, .wa_h0, .wa_h1, .commit_len
  );

  rxr_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk, .we_d, .wa_d, .wd_d,
    .we_h(commit), .wa_h0, .wa_h1, .wd_h0(commit_len[15:8]), .wd_h1(commit_len[7:0]),
    .ra_x, .rd_x, .ra_h0, .ra_h1, .rd_h0, .rd_h1
  );

  rxr_drain #(.DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME), .AW(AW), .LW(LW)) u_drain (
    .clk, .rst_n, .frame_cnt_nz, .evict_req, .rd_h0, .rd_h1, .rd_x,
    .ra_x, .ra_h0, .ra_h1, .head_len, .out_valid, .out_ready,
    .out_data, .out_last, .pop, .rd_lost
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used      <= '0;
      frame_cnt <= '0;
      rx_irq    <= 1'b0;
    end else begin
      rx_irq    <= commit;
      used      <= CW'(int'(used)
                   + (commit ? int'(commit_len) + int'(HDR_BYTES) : 0)
                   - (pop    ? int'(head_len)   + int'(HDR_BYTES) : 0));
      frame_cnt <= CW'(int'(frame_cnt) + (commit ? 1 : 0) - (pop ? 1 : 0));
    end
  end

  assign stat_frames   = frame_cnt;
  assign stat_head_len = frame_cnt_nz ? head_len : 16'd0;

  // R1
  capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(used) <= DEPTH);

  // R1
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_cnt == '0) |-> (used == '0));

  // R6
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> frame_cnt_nz);
endmodule

// File: tb/rx_frame_ring_bench.sv
module rx_frame_ring_bench;
  localparam int DEPTH = 64;
  localparam int MAXF  = 20;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0, out_ready = 0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last, rx_irq, rd_lost;
  logic [7:0] out_data;
  logic [CW-1:0] stat_frames;
  logic [15:0] stat_head_len;

  always #5 clk = ~clk;

  rx_frame_ring #(.DEPTH(DEPTH), .MAX_FRAME(MAXF)) u_rx_frame_ring (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sof, .in_eof, .in_err,
    .out_valid, .out_ready, .out_data, .out_last, .rx_irq, .rd_lost,
    .stat_frames, .stat_head_len
  );

  int n_chk = 0, n_bad = 0;
  int irq_cnt = 0, lost_cnt = 0, stall_cnt = 0;
  int q_len[$], q_seed[$];

  always @(posedge clk) begin
    if (rx_irq) irq_cnt++;
    if (rd_lost) lost_cnt++;
    if (in_valid && !in_ready) stall_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(input int s, input int i);
    return 8'((s * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic int m_used();
    int u = 0;
    foreach (q_len[k]) u += q_len[k] + 2;
    return u;
  endfunction

  task automatic make_room(input int n);
    while (m_used() + n + 2 > DEPTH && q_len.size() > 0) begin
      void'(q_len.pop_front());
      void'(q_seed.pop_front());
    end
  endtask

  task automatic chk_status(input string req);
    int hl = (q_len.size() == 0) ? 0 : q_len[0];
    chk(int'(stat_frames) == q_len.size(), req, int'(stat_frames), q_len.size());
    chk(int'(stat_head_len) == hl, req, int'(stat_head_len), hl);
  endtask

  // chk_at > 0: pause before that byte and verify the partial frame is invisible (R7)
  task automatic send_raw(input int len, input int seed, input bit sof,
                          input bit eof, input bit err, input int chk_at);
    bit commit = sof && eof && !err && (len <= MAXF);
    int ibefore = irq_cnt;
    if (sof) make_room((len < MAXF) ? len : MAXF);
    for (int i = 0; i < len; i++) begin
      if (i == chk_at && i > 0) begin
        @(negedge clk);
        in_valid = 0;
        @(negedge clk);
        @(negedge clk);
        chk(int'(stat_frames) == q_len.size(), "R7", int'(stat_frames), q_len.size());
        chk(out_valid == (q_len.size() != 0), "R7", out_valid, q_len.size() != 0);
      end
      @(negedge clk);
      in_valid = 1;
      in_data  = pb(seed, i);
      in_sof   = sof && (i == 0);
      in_eof   = eof && (i == len - 1);
      in_err   = err && (i == len - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0;
    if (commit) begin
      q_len.push_back(len);
      q_seed.push_back(seed);
    end
    if (eof) begin
      chk(rx_irq == commit, "R6", rx_irq, commit);
      chk(irq_cnt - ibefore == (commit ? 0 : 0), "R6", irq_cnt - ibefore, 0);
      @(negedge clk);
      chk(rx_irq == 1'b0, "R6", rx_irq, 0);
      chk(irq_cnt - ibefore == int'(commit), "R6", irq_cnt - ibefore, int'(commit));
    end
    chk_status("R10");
  endtask

  task automatic read_bytes(input int len, input int seed, input int nbytes, input bit stall);
    logic [7:0] held;
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      if (stall && i == 1) begin
        out_ready = 0;
        held = out_data;
        @(negedge clk);
        chk(out_valid && out_data == held, "R11", out_data, held);
      end
      out_ready = 1;
      chk(out_valid == 1'b1, "R2", out_valid, 1);
      chk(out_data == pb(seed, i), "R2", out_data, pb(seed, i));
      chk(out_last == (i == len - 1), "R2", out_last, i == len - 1);
    end
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic drain_one(input bit stall);
    int l = q_len.pop_front();
    int s = q_seed.pop_front();
    read_bytes(l, s, l, stall);
    chk_status("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12
    chk(in_ready == 1'b1, "R12", in_ready, 1);
    chk(out_valid == 1'b0, "R12", out_valid, 0);
    chk(rx_irq == 1'b0 && rd_lost == 1'b0, "R12", rx_irq, 0);
    chk_status("R12");

    // R2 R4 R6 R1: every legal length, store then drain; pointers wrap
    for (int L = 1; L <= MAXF; L++) begin
      send_raw(L, L, 1, 1, 0, (L > 4) ? L / 2 : 0);
      drain_one(L > 2);
    end

    // R4: oversize frames rejected, exact maximum kept
    send_raw(MAXF + 1, 50, 1, 1, 0, 0);
    send_raw(MAXF + 5, 51, 1, 1, 0, 0);
    chk(int'(stat_frames) == 0, "R4", int'(stat_frames), 0);
    send_raw(MAXF, 52, 1, 1, 0, 0);
    drain_one(0);

    // R5: error frame discarded, space reused
    send_raw(5, 60, 1, 1, 1, 0);
    chk(int'(stat_frames) == 0, "R5", int'(stat_frames), 0);
    send_raw(8, 61, 1, 1, 0, 0);
    drain_one(1);

    // R3: stray bytes ignored, restart on a new start marker
    send_raw(3, 70, 0, 1, 0, 0);
    chk(int'(stat_frames) == 0, "R3", int'(stat_frames), 0);
    send_raw(4, 71, 1, 0, 0, 0);
    send_raw(6, 72, 1, 1, 0, 3);
    chk(int'(stat_head_len) == 6, "R3", int'(stat_head_len), 6);
    drain_one(0);

    // R8: fill past capacity, oldest frames evicted
    begin
      int st0 = stall_cnt;
      for (int k = 0; k < 7; k++) send_raw(10, 40 + k, 1, 1, 0, 0);
      chk(int'(stat_frames) == 5, "R8", int'(stat_frames), 5);
      chk(q_seed[0] == 42, "R8", q_seed[0], 42);
      chk(stall_cnt > st0, "R8", stall_cnt - st0, 1);
      chk(lost_cnt == 0, "R9", lost_cnt, 0);
      while (q_len.size() > 0) drain_one(0);
    end

    // R9: evict a frame mid-read
    send_raw(MAXF, 80, 1, 1, 0, 0);
    send_raw(MAXF, 81, 1, 1, 0, 0);
    read_bytes(MAXF, 80, 3, 0);
    send_raw(MAXF, 82, 1, 1, 0, 0);
    chk(lost_cnt == 1, "R9", lost_cnt, 1);
    chk(q_seed[0] == 81, "R9", q_seed[0], 81);
    drain_one(0);
    drain_one(1);
    chk(lost_cnt == 1, "R9", lost_cnt, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule